// File: doc/BRIEF.md
# Fetch Stage With Branch Target History

This block is the front stage of a three-stage in-order pipeline (fetch, decode, execute). Every cycle it presents an instruction address to instruction memory, which answers in the same cycle. One cycle later it hands the fetched word and its address to decode. The fetch address advances on its own by one instruction word per cycle. The only things that change that are a stall from downstream, a hit in a small table of branch targets, or a correction from execute.

The target table is direct-mapped. The low bits of the address select an entry, and the remaining bits are kept as a tag. A fetched address that finds a matching valid entry sends the next fetch to the target that branch took the last time it resolved taken. Execute reports every branch it completes on a resolve port. The report gives the branch address, whether it was taken, and its target. When the true next address differs from the one fetched behind the branch, the instruction waiting in decode and the one being fetched are dropped and become empty slots, and fetch restarts at the true address. A running count of dropped slots lets the cost of wrong guesses be measured from outside.

Top module: `fetch_btb_stage`

## Requirements
- R1: While reset is asserted and at its release, the decode output is not valid, the fetch address is 0 and the squash count is 0. Reset also empties the target table, so a branch trained before reset is not predicted after it.
- R2: When the fetch address misses in the table and the fetch is accepted, the next fetch address is the current one plus 1. The fetched word and its address appear on the decode output after the next clock edge.
- R3: While the decode output is valid and `dec_ready` is low, the fetch address and the decode output hold their values. When `dec_ready` returns high, decode receives the held fetch address.
- R4: A resolve report arrives in the cycle after execute accepted the branch. Its true next address is the target if the branch was taken, or the branch address plus 1 if not. If that differs from the address fetched after the branch, the decode output is invalid in that cycle and in the next one, and the next fetch address is the true next address.
- R5: When the fetch address hits a valid entry whose tag matches, the next fetch address is that entry's stored target.
- R6: The entry index is the low log2(ENTRIES) address bits and the tag is the remaining upper bits. A taken report writes its tag and target into the entry. A not-taken report clears the entry only when its tag matches. An address with the same index but a different tag misses.
- R7: A backward branch that closes a loop and is executed several times is mispredicted only on its first execution and on its last, not-taken one.
- R8: Each misprediction adds 1 to the squash count, plus 1 more if the decode slot held an instruction. In every other cycle the count does not change.
- R9: With `dec_ready` held high, the cycles without a decode handoff, counted between the first and last handoff, equal the squash count.
- R10: A branch that has never been taken and resolves not-taken causes no misprediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_req_valid | output | 1 | The word at `imem_req_addr` is taken into decode at this edge |
| imem_req_addr | output | PC_W | Current fetch address, in instruction words |
| imem_rsp_data | input | INSTR_W | Instruction word at `imem_req_addr`, same cycle |
| dec_valid | output | 1 | Decode slot holds a live instruction |
| dec_ready | input | 1 | Execute accepts the decode slot at this edge |
| dec_pc | output | PC_W | Address of the instruction in decode |
| dec_instr | output | INSTR_W | Instruction word in decode |
| res_valid | input | 1 | Execute reports a resolved branch this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | The branch was taken |
| res_target | input | PC_W | Target of the branch when taken |
| squash_count | output | CNT_W | Running total of dropped pipeline slots |

## Verification
A corrupted table entry shows up as a wrong fetch address one cycle after the branch is fetched. When that branch resolves two cycles later, it also shows up as two empty decode cycles and a squash count larger than expected. A fetch or decode register that fails to hold under a stall shows up on `imem_req_addr` or `dec_pc` at the very next edge. A missed or wrong redirect breaks the sequence of addresses handed to execute at the first instruction after the branch. That sequence is compared against the architectural path, so every such fault is visible within a few cycles of its cause.

// File: rtl/fbt_pkg.sv
package fbt_pkg;

   localparam int DEF_PC_W    = 16;
   localparam int DEF_INSTR_W = 32;
   localparam int DEF_ENTRIES = 16;
   localparam int DEF_CNT_W   = 16;

   // action taken on the fetch/decode pair in one cycle
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_KILL = 2'd2
   } slot_act_e;

endpackage

// File: rtl/fbt_target_table.sv
module fbt_target_table #(
   parameter int PC_W    = 16,
   parameter int ENTRIES = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] look_pc,
   output logic            look_hit,
   output logic [PC_W-1:0] look_target,
   input  logic            upd_valid,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_pc,
   input  logic [PC_W-1:0] upd_target
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int TAG_W = PC_W - IDX_W;

   logic [ENTRIES-1:0] ent_valid;
   logic [TAG_W-1:0]   ent_tag [ENTRIES];
   logic [PC_W-1:0]    ent_tgt [ENTRIES];

   logic [IDX_W-1:0] look_idx, upd_idx;
   logic [TAG_W-1:0] look_tag, upd_tag;

   assign look_idx = look_pc[IDX_W-1:0];
   assign look_tag = look_pc[PC_W-1:IDX_W];
   assign upd_idx  = upd_pc[IDX_W-1:0];
   assign upd_tag  = upd_pc[PC_W-1:IDX_W];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic             v_q;
      logic [TAG_W-1:0] tag_q;
      logic [PC_W-1:0]  tgt_q;
      logic             sel;

      assign sel = upd_valid && (upd_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
         end else if (sel) begin
            if (upd_taken) begin
               v_q <= 1'b1;
            end else if (tag_q == upd_tag) begin
               v_q <= 1'b0;
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_q <= '0;
            tgt_q <= '0;
         end else if (sel && upd_taken) begin
            tag_q <= upd_tag;
            tgt_q <= upd_target;
         end
      end

      assign ent_valid[e] = v_q;
      assign ent_tag[e]   = tag_q;
      assign ent_tgt[e]   = tgt_q;
   end

   assign look_hit    = ent_valid[look_idx] && (ent_tag[look_idx] == look_tag);
   assign look_target = ent_tgt[look_idx];

endmodule

// File: rtl/fbt_redirect.sv
module fbt_redirect #(
   parameter int PC_W = 16
) (
   input  logic [PC_W-1:0] fetch_pc,
   input  logic            look_hit,
   input  logic [PC_W-1:0] look_target,
   input  logic            ex_live,
   input  logic [PC_W-1:0] ex_pred_next,
   input  logic            res_valid,
   input  logic [PC_W-1:0] res_pc,
   input  logic            res_taken,
   input  logic [PC_W-1:0] res_target,
   output logic [PC_W-1:0] pred_next,
   output logic [PC_W-1:0] fix_pc,
   output logic            mispredict
);
   assign pred_next  = look_hit ? look_target : fetch_pc + PC_W'(1);
   assign fix_pc     = res_taken ? res_target : res_pc + PC_W'(1);
   assign mispredict = res_valid && ex_live && (fix_pc != ex_pred_next);

endmodule

// File: rtl/fbt_squash_ctr.sv
module fbt_squash_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kill,
   input  logic             dec_occupied,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (kill) begin
         count <= count + CNT_W'(1) + CNT_W'(dec_occupied);
      end
   end

endmodule

// File: rtl/fetch_btb_stage.sv
module fetch_btb_stage
   import fbt_pkg::*;
#(
   parameter int PC_W    = DEF_PC_W,
   parameter int INSTR_W = DEF_INSTR_W,
   parameter int ENTRIES = DEF_ENTRIES,
   parameter int CNT_W   = DEF_CNT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic               imem_req_valid,
   output logic [PC_W-1:0]    imem_req_addr,
   input  logic [INSTR_W-1:0] imem_rsp_data,
   output logic               dec_valid,
   input  logic               dec_ready,
   output logic [PC_W-1:0]    dec_pc,
   output logic [INSTR_W-1:0] dec_instr,
   input  logic               res_valid,
   input  logic [PC_W-1:0]    res_pc,
   input  logic               res_taken,
   input  logic [PC_W-1:0]    res_target,
   output logic [CNT_W-1:0]   squash_count
);
   localparam int IDX_W = $clog2(ENTRIES);

   initial begin
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0)
         $fatal(1, "ENTRIES must be a power of two of at least 2");
      if (PC_W <= IDX_W)
         $fatal(1, "PC_W must exceed the table index width");
      if (CNT_W < 2)
         $fatal(1, "CNT_W must be at least 2");
   end

   logic [PC_W-1:0]    fetch_pc;
   logic               dec_valid_q;
   logic [PC_W-1:0]    dec_pc_q;
   logic [PC_W-1:0]    dec_pred_q;
   logic [INSTR_W-1:0] dec_instr_q;
   logic               ex_live;
   logic [PC_W-1:0]    ex_pred_next;

   logic               look_hit;
   logic [PC_W-1:0]    look_target;
   logic [PC_W-1:0]    pred_next;
   logic [PC_W-1:0]    fix_pc;
   logic               mispredict;
   logic               handoff;
   slot_act_e          act;

   fbt_target_table #(
      .PC_W    (PC_W),
      .ENTRIES (ENTRIES)
   ) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .look_pc     (fetch_pc),
      .look_hit    (look_hit),
      .look_target (look_target),
      .upd_valid   (res_valid),
      .upd_taken   (res_taken),
      .upd_pc      (res_pc),
      .upd_target  (res_target)
   );

   fbt_redirect #(
      .PC_W (PC_W)
   ) u_redirect (
      .fetch_pc     (fetch_pc),
      .look_hit     (look_hit),
      .look_target  (look_target),
      .ex_live      (ex_live),
      .ex_pred_next (ex_pred_next),
      .res_valid    (res_valid),
      .res_pc       (res_pc),
      .res_taken    (res_taken),
      .res_target   (res_target),
      .pred_next    (pred_next),
      .fix_pc       (fix_pc),
      .mispredict   (mispredict)
   );

   fbt_squash_ctr #(
      .CNT_W (CNT_W)
   ) u_squash (
      .clk          (clk),
      .rst_n        (rst_n),
      .kill         (mispredict),
      .dec_occupied (dec_valid_q),
      .count        (squash_count)
   );

   always_comb begin
      if (mispredict)
         act = ACT_KILL;
      else if (!dec_valid_q || dec_ready)
         act = ACT_LOAD;
      else
         act = ACT_HOLD;
   end

   assign imem_req_valid = (act == ACT_LOAD);
   assign imem_req_addr  = fetch_pc;
   assign dec_valid      = dec_valid_q && !mispredict;
   assign dec_pc         = dec_pc_q;
   assign dec_instr      = dec_instr_q;
   assign handoff        = dec_valid && dec_ready;

   // fetch address and decode slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_pc    <= '0;
         dec_valid_q <= 1'b0;
         dec_pc_q    <= '0;
         dec_pred_q  <= '0;
         dec_instr_q <= '0;
      end else begin
         case (act)
            ACT_KILL: begin
               fetch_pc    <= fix_pc;
               dec_valid_q <= 1'b0;
            end
            ACT_LOAD: begin
               fetch_pc    <= pred_next;
               dec_valid_q <= 1'b1;
               dec_pc_q    <= fetch_pc;
               dec_pred_q  <= pred_next;
               dec_instr_q <= imem_rsp_data;
            end
            default: begin
            end
         endcase
      end
   end

   // record of what was fetched behind the instruction now in execute
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ex_live      <= 1'b0;
         ex_pred_next <= '0;
      end else begin
         ex_live <= handoff;
         if (handoff)
            ex_pred_next <= dec_pred_q;
      end
   end

endmodule

// File: rtl/fbt_checker.sv
module fbt_checker #(
   parameter int PC_W  = 16,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             imem_req_valid,
   input logic [PC_W-1:0]  imem_req_addr,
   input logic             dec_valid,
   input logic [PC_W-1:0]  dec_pc,
   input logic [CNT_W-1:0] squash_count,
   input logic             mispredict,
   input logic [PC_W-1:0]  fix_pc,
   input logic             look_hit,
   input logic [PC_W-1:0]  look_target
);
   p_seq_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
      imem_req_valid && !look_hit |=> imem_req_addr == PC_W'($past(imem_req_addr) + PC_W'(1)));

   p_dec_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      imem_req_valid |=> dec_pc == $past(imem_req_addr));

   p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !imem_req_valid && !mispredict |=> $stable(imem_req_addr) && $stable(dec_pc));

   p_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |=> imem_req_addr == $past(fix_pc) && !dec_valid);

   p_hit_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      imem_req_valid && look_hit |=> imem_req_addr == $past(look_target));

   p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !mispredict |=> $stable(squash_count));

   p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |=> squash_count != $past(squash_count));

endmodule

bind fetch_btb_stage fbt_checker #(
   .PC_W  (PC_W),
   .CNT_W (CNT_W)
) u_fbt_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .imem_req_valid (imem_req_valid),
   .imem_req_addr  (imem_req_addr),
   .dec_valid      (dec_valid),
   .dec_pc         (dec_pc),
   .squash_count   (squash_count),
   .mispredict     (mispredict),
   .fix_pc         (fix_pc),
   .look_hit       (look_hit),
   .look_target    (look_target)
);

// File: tb/tb_fetch_btb_stage.sv
`timescale 1ns/1ps
module tb_fetch_btb_stage;
   localparam int PC_W    = 16;
   localparam int INSTR_W = 32;
   localparam int ENTRIES = 16;
   localparam int CNT_W   = 16;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               imem_req_valid;
   logic [PC_W-1:0]    imem_req_addr;
   logic [INSTR_W-1:0] imem_rsp_data;
   logic               dec_valid;
   logic               dec_ready = 1'b1;
   logic [PC_W-1:0]    dec_pc;
   logic [INSTR_W-1:0] dec_instr;
   logic               res_valid = 1'b0;
   logic [PC_W-1:0]    res_pc = '0;
   logic               res_taken = 1'b0;
   logic [PC_W-1:0]    res_target = '0;
   logic [CNT_W-1:0]   squash_count;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   // instruction memory: word carries its own address
   assign imem_rsp_data = {16'hC0DE, imem_req_addr};

   fetch_btb_stage #(
      .PC_W(PC_W), .INSTR_W(INSTR_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .imem_req_valid(imem_req_valid), .imem_req_addr(imem_req_addr),
      .imem_rsp_data(imem_rsp_data),
      .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_pc(dec_pc), .dec_instr(dec_instr),
      .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken), .res_target(res_target),
      .squash_count(squash_count)
   );

   typedef struct packed {
      logic [15:0] br;    // branch address
      logic [15:0] tgt;   // its target
      logic [31:0] mask;  // bit k: taken on k-th execution
      logic [15:0] wrap;  // always-taken branch to 0 (FFFF = none)
      logic [15:0] run;   // handoffs to observe
      logic [15:0] sq;    // expected squash count
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{16'd5,  16'd2,  32'h7,   16'hFFFF, 16'd22,  16'd4}, // R7 loop
      '{16'd9,  16'd9,  32'h1F,  16'hFFFF, 16'd18,  16'd4}, // R7 self loop
      '{16'd2,  16'd7,  32'h1,   16'hFFFF, 16'd12,  16'd2}, // R4 forward
      '{16'd4,  16'd1,  32'h0,   16'hFFFF, 16'd10,  16'd0}, // R10 never taken
      '{16'd3,  16'd40, 32'h1,   16'hFFFF, 16'd60,  16'd2}, // R6 same index other tag
      '{16'd20, 16'd12, 32'h3FF, 16'hFFFF, 16'd114, 16'd4}, // R7 long loop
      '{16'd2,  16'd7,  32'h1,   16'hFFFF, 16'd12,  16'd2}, // R1 table cleared by reset
      '{16'd3,  16'd1,  32'h1,   16'd6,    16'd20,  16'd6}  // R6 not-taken invalidates
   };

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; res_valid = 1'b0; dec_ready = 1'b1;
      repeat (3) @(negedge clk);
      check(dec_valid == 1'b0, "R1", "reset dec_valid", dec_valid, 0);
      check(imem_req_addr == 0, "R1", "reset fetch addr", imem_req_addr, 0);
      check(squash_count == 0, "R1", "reset squash count", squash_count, 0);
      rst_n = 1'b1;
   endtask

   task automatic run_vec(input vec_t v, input int n);
      int hand = 0, bub = 0, guard = 0, ex_cnt = 0, arch_cnt = 0, terr = 0;
      bit pend_v = 0, started = 0, tk;
      logic [15:0] pend_pc = '0, exp_pc = '0, bad_act = '0, bad_exp = '0;
      do_reset();
      while (hand < int'(v.run) && guard < 4000) begin
         @(negedge clk);
         guard++;
         // execute model: resolve the branch accepted at the last edge
         if (pend_v && (pend_pc == v.br || pend_pc == v.wrap)) begin
            res_valid = 1'b1;
            res_pc    = pend_pc;
            if (pend_pc == v.wrap) begin
               res_taken = 1'b1; res_target = '0;
            end else begin
               res_taken  = (ex_cnt < 32) ? v.mask[ex_cnt] : 1'b0;
               res_target = v.tgt;
               ex_cnt++;
            end
         end else begin
            res_valid = 1'b0;
         end
         #1;
         if (dec_valid) begin
            if (dec_pc !== exp_pc || dec_instr !== {16'hC0DE, exp_pc}) begin
               if (terr == 0) begin bad_act = dec_pc; bad_exp = exp_pc; end
               terr++;
            end
            if (exp_pc == v.wrap) begin
               exp_pc = '0;
            end else if (exp_pc == v.br) begin
               tk = (arch_cnt < 32) ? v.mask[arch_cnt] : 1'b0;
               arch_cnt++;
               exp_pc = tk ? v.tgt : exp_pc + 16'd1;
            end else begin
               exp_pc = exp_pc + 16'd1;
            end
            hand++; started = 1; pend_v = 1; pend_pc = dec_pc;
         end else begin
            pend_v = 0;
            if (started) bub++;
         end
      end
      @(negedge clk);
      res_valid = 1'b0;
      check(guard < 4000, "R2", $sformatf("vec %0d handoffs", n), hand, v.run);
      // trace along the architectural path: R2 R4 R5 R6
      check(terr == 0, "R2 R4 R5 R6", $sformatf("vec %0d handed-off pc", n), bad_act, bad_exp);
      // squash total: R7 R8 R10 (R1 for the repeated vector)
      check(squash_count == v.sq, "R7 R8 R10", $sformatf("vec %0d squash count", n),
            squash_count, v.sq);
      // empty decode cycles equal squashed slots: R9
      check(bub == int'(squash_count), "R9", $sformatf("vec %0d bubble cycles", n),
            bub, squash_count);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [PC_W-1:0] held_a, held_p;

      // directed: reset and sequential start (R1, R2)
      do_reset();
      @(negedge clk);
      check(dec_valid && dec_pc == 0, "R2", "first decode pc", dec_pc, 0);
      check(dec_instr == {16'hC0DE, 16'd0}, "R2", "first decode word", dec_instr, {16'hC0DE, 16'd0});
      check(imem_req_addr == 1, "R2", "second fetch addr", imem_req_addr, 1);

      // directed: stall holds fetch and decode (R3)
      repeat (2) @(negedge clk);
      dec_ready = 1'b0;
      held_a = imem_req_addr;
      held_p = dec_pc;
      repeat (3) @(negedge clk);
      check(imem_req_addr == held_a, "R3", "fetch addr under stall", imem_req_addr, held_a);
      check(dec_pc == held_p, "R3", "decode pc under stall", dec_pc, held_p);
      check(dec_valid == 1'b1, "R3", "decode valid under stall", dec_valid, 1);
      dec_ready = 1'b1;
      @(negedge clk);
      check(dec_pc == held_a, "R3", "decode pc after stall", dec_pc, held_a);

      // vector table
      for (int i = 0; i < 8; i++) begin
         run_vec(VECS[i], i);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule